// File: doc/BRIEF.md
# Blanking-Aligned Buffer Swap Controller

This block chooses which framebuffer the scanout engine reads and which one the renderer writes. It holds the base addresses of two or three framebuffers. It also runs the raster position counters, which advance on pixel-clock ticks, and it emits a strobe at the start of each frame and at the start of vertical blanking. When the renderer finishes a frame it raises a flip request. The controller records that request and changes the exported display base only when the raster enters vertical blanking. A scanned frame therefore never mixes two images. No pixel data is copied: a flip only reloads the display start address.

A mode input selects one of two schemes. In the two-buffer scheme, the renderer must wait after a request until the swap has happened. In the three-buffer scheme, the renderer moves at once to a spare buffer while the finished frame waits for blanking. If a newer frame finishes before blanking arrives, it replaces the waiting one.

Top module: `flip_sync_ctrl`

## Requirements
- R1: After reset, display_base is BASE0 and render_base is BASE1. No flip is pending, render_ready is 1, both positions are 0, and frame_start, vblank_start and flip_done are all 0.
- R2: The horizontal position advances by one on each cycle with pix_tick high and wraps to 0 after H_ACTIVE+H_BLANK-1. The vertical position advances on that wrap and wraps to 0 after V_ACTIVE+V_BLANK-1. Without a tick neither position changes. active_video is high exactly when h_pos < H_ACTIVE and v_pos < V_ACTIVE.
- R3: vblank_start is high for one clock cycle, the cycle after the tick that moves the raster to (h 0, v V_ACTIVE). frame_start is high for one cycle after the tick that moves it to (0, 0).
- R4: display_base changes only in a cycle where flip_done is high. flip_done is high only together with vblank_start.
- R5: With triple_en low, an accepted flip_req drops render_ready from the next cycle until the cycle of the swap. flip_req while render_ready is low is ignored.
- R6: With triple_en low, the swap at blanking makes the finished render buffer the display buffer. The old display buffer becomes the render buffer.
- R7: With triple_en high, a flip_req queues the current render buffer. In the next cycle render_base moves to the buffer that is neither displayed nor queued. render_ready stays 1.
- R8: With triple_en high, a second flip_req before blanking queues the newest buffer. The buffer it displaces becomes the render buffer. At blanking, display_base takes the newest queued buffer.
- R9: A flip_req in the same cycle as the tick that enters blanking is included in that swap.
- R10: Entering blanking with nothing pending leaves both bases unchanged and gives no flip_done.
- R11: display_base and render_base never hold the same buffer. triple_en may change only while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_tick | input | 1 | Pixel clock enable; one raster step per high cycle |
| triple_en | input | 1 | 1 selects three buffers, 0 selects two |
| flip_req | input | 1 | Renderer has finished the frame in render_base |
| h_pos | output | HW | Horizontal raster position |
| v_pos | output | VW | Vertical raster position |
| active_video | output | 1 | Raster is inside the visible area |
| frame_start | output | 1 | One-cycle strobe on return to (0,0) |
| vblank_start | output | 1 | One-cycle strobe on the first blank line |
| display_base | output | ADDR_W | Start address the scanout reads |
| render_base | output | ADDR_W | Start address the renderer writes |
| render_ready | output | 1 | Renderer may start a frame in render_base |
| flip_done | output | 1 | Display base changed this cycle |

## Verification
The tick that enters vertical blanking and a renderer request can fall on the same clock edge. The request must then join that swap instead of waiting a whole frame. The bench provokes this on purpose: whenever the next tick will move the raster onto the first blank line, it raises flip_req in that same cycle about half the time, in both modes. The behavioural model applies the request before the blanking swap. The cycle-by-cycle comparison then judges three things: flip_done and display_base in the next cycle, and in the three-buffer mode the render base left after the queued buffer has gone to display.

// File: rtl/flip_pkg.sv
package flip_pkg;
  typedef logic [1:0] buf_idx_t;

  localparam buf_idx_t BUF_A = 2'd0;
  localparam buf_idx_t BUF_B = 2'd1;
  localparam buf_idx_t BUF_C = 2'd2;

  // Buffer indices 0,1,2 sum to 3, so the remaining one is 3 - a - b.
  function automatic buf_idx_t other_buf(input buf_idx_t a, input buf_idx_t b);
    buf_idx_t r;
    r = 2'd3 - a - b;
    return r;
  endfunction
endpackage

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int H_ACTIVE = 640,
  parameter int H_BLANK  = 160,
  parameter int V_ACTIVE = 480,
  parameter int V_BLANK  = 45,
  localparam int H_TOTAL = H_ACTIVE + H_BLANK,
  localparam int V_TOTAL = V_ACTIVE + V_BLANK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          active,
  output logic          enter_blank,
  output logic          frame_strobe,
  output logic          blank_strobe
);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT_LAST = VW'(V_ACTIVE - 1);
  localparam logic [HW-1:0] H_ACT_END  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_ACT_END  = VW'(V_ACTIVE);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          fs_q, fs_d;
  logic          vb_q, vb_d;
  logic          line_end;
  logic          enter_frame;

  always_comb begin
    line_end    = tick && (h_q == H_LAST);
    enter_blank = line_end && (v_q == V_ACT_LAST);
    enter_frame = line_end && (v_q == V_LAST);
    h_d = h_q;
    v_d = v_q;
    if (tick) begin
      h_d = (h_q == H_LAST) ? '0 : h_q + 1'b1;
    end
    if (line_end) begin
      v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
    fs_d = enter_frame;
    vb_d = enter_blank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= '0;
      v_q  <= '0;
      fs_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      h_q  <= h_d;
      v_q  <= v_d;
      fs_q <= fs_d;
      vb_q <= vb_d;
    end
  end

  assign h_pos        = h_q;
  assign v_pos        = v_q;
  assign active       = (h_q < H_ACT_END) && (v_q < V_ACT_END);
  assign frame_strobe = fs_q;
  assign blank_strobe = vb_q;
endmodule

// File: rtl/buffer_roles.sv
module buffer_roles
  import flip_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     triple_en,
  input  logic     flip_req,
  input  logic     swap_ev,
  output buf_idx_t disp_idx,
  output buf_idx_t rend_idx,
  output logic     ready,
  output logic     swapped
);
  buf_idx_t disp_q, disp_d;
  buf_idx_t rend_q, rend_d;
  buf_idx_t pend_q, pend_d;
  logic     pv_q, pv_d;
  logic     done_q, done_d;

  // Pending state after taking this cycle's request, before the swap.
  buf_idx_t eff_rend;
  buf_idx_t eff_pend;
  logic     eff_pv;
  logic     req_ok;

  always_comb begin
    req_ok   = flip_req && (triple_en || !pv_q);
    eff_rend = rend_q;
    eff_pend = pend_q;
    eff_pv   = pv_q;
    if (req_ok) begin
      eff_pv   = 1'b1;
      eff_pend = rend_q;
      if (triple_en) begin
        eff_rend = pv_q ? pend_q : other_buf(disp_q, rend_q);
      end
    end

    disp_d = disp_q;
    rend_d = eff_rend;
    pend_d = eff_pend;
    pv_d   = eff_pv;
    done_d = 1'b0;
    if (swap_ev && eff_pv) begin
      disp_d = eff_pend;
      pv_d   = 1'b0;
      done_d = 1'b1;
      if (!triple_en) begin
        rend_d = disp_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= BUF_A;
      rend_q <= BUF_B;
      pend_q <= BUF_A;
      pv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      disp_q <= disp_d;
      rend_q <= rend_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      done_q <= done_d;
    end
  end

  assign disp_idx = disp_q;
  assign rend_idx = rend_q;
  assign ready    = triple_en || !pv_q;
  assign swapped  = done_q;
endmodule

// File: rtl/base_select.sv
module base_select
  import flip_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE0 = '0,
  parameter logic [ADDR_W-1:0] BASE1 = '0,
  parameter logic [ADDR_W-1:0] BASE2 = '0
) (
  input  buf_idx_t          idx,
  output logic [ADDR_W-1:0] base
);
  always_comb begin
    unique case (idx)
      BUF_A:   base = BASE0;
      BUF_B:   base = BASE1;
      default: base = BASE2;
    endcase
  end
endmodule

// File: rtl/flip_sync_ctrl.sv
module flip_sync_ctrl
  import flip_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BASE0 = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] BASE1 = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] BASE2 = 32'h0020_0000,
  parameter int H_ACTIVE = 640,
  parameter int H_BLANK  = 160,
  parameter int V_ACTIVE = 480,
  parameter int V_BLANK  = 45,
  localparam int HW      = $clog2(H_ACTIVE + H_BLANK),
  localparam int VW      = $clog2(V_ACTIVE + V_BLANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_tick,
  input  logic              triple_en,
  input  logic              flip_req,
  output logic [HW-1:0]     h_pos,
  output logic [VW-1:0]     v_pos,
  output logic              active_video,
  output logic              frame_start,
  output logic              vblank_start,
  output logic [ADDR_W-1:0] display_base,
  output logic [ADDR_W-1:0] render_base,
  output logic              render_ready,
  output logic              flip_done
);
  logic     rst_n_i;
  logic     enter_blank;
  buf_idx_t disp_idx;
  buf_idx_t rend_idx;

  reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  raster_timer #(
    .H_ACTIVE (H_ACTIVE),
    .H_BLANK  (H_BLANK),
    .V_ACTIVE (V_ACTIVE),
    .V_BLANK  (V_BLANK)
  ) u_raster (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .tick         (pix_tick),
    .h_pos        (h_pos),
    .v_pos        (v_pos),
    .active       (active_video),
    .enter_blank  (enter_blank),
    .frame_strobe (frame_start),
    .blank_strobe (vblank_start)
  );

  buffer_roles u_roles (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .triple_en (triple_en),
    .flip_req  (flip_req),
    .swap_ev   (enter_blank),
    .disp_idx  (disp_idx),
    .rend_idx  (rend_idx),
    .ready     (render_ready),
    .swapped   (flip_done)
  );

  base_select #(.ADDR_W(ADDR_W), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)) u_disp_sel (
    .idx  (disp_idx),
    .base (display_base)
  );

  base_select #(.ADDR_W(ADDR_W), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)) u_rend_sel (
    .idx  (rend_idx),
    .base (render_base)
  );
endmodule

// File: rtl/flip_sync_chk.sv
module flip_sync_chk #(
  parameter int ADDR_W   = 32,
  parameter int V_ACTIVE = 480,
  parameter int HW       = 10,
  parameter int VW       = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_tick,
  input logic              triple_en,
  input logic [HW-1:0]     h_pos,
  input logic [VW-1:0]     v_pos,
  input logic              vblank_start,
  input logic [ADDR_W-1:0] display_base,
  input logic [ADDR_W-1:0] render_base,
  input logic              render_ready,
  input logic              flip_done
);
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_tick |=> ($stable(h_pos) && $stable(v_pos)));

  p_vblank_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> !vblank_start);

  p_vblank_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |-> (h_pos == '0 && v_pos == VW'(V_ACTIVE)));

  p_base_moves_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (display_base != $past(display_base)) |-> flip_done);

  p_done_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> vblank_start);

  p_ready_triple_r7: assert property (@(posedge clk) disable iff (!rst_n)
    triple_en |-> render_ready);

  p_bases_differ_r11: assert property (@(posedge clk) disable iff (!rst_n)
    display_base != render_base);
endmodule

bind flip_sync_ctrl flip_sync_chk #(
  .ADDR_W   (ADDR_W),
  .V_ACTIVE (V_ACTIVE),
  .HW       (HW),
  .VW       (VW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_tick     (pix_tick),
  .triple_en    (triple_en),
  .h_pos        (h_pos),
  .v_pos        (v_pos),
  .vblank_start (vblank_start),
  .display_base (display_base),
  .render_base  (render_base),
  .render_ready (render_ready),
  .flip_done    (flip_done)
);

// File: tb/test_flip_sync_ctrl.sv
module test_flip_sync_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int HA  = 6;
  localparam int HB  = 2;
  localparam int VA  = 4;
  localparam int VB  = 2;
  localparam int HT  = HA + HB;
  localparam int VT  = VA + VB;
  localparam int HW  = $clog2(HT);
  localparam int VW  = $clog2(VT);
  localparam logic [AW-1:0] B0 = 32'h1000_0000;
  localparam logic [AW-1:0] B1 = 32'h2000_0000;
  localparam logic [AW-1:0] B2 = 32'h3000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_tick, triple_en, flip_req;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic active_video, frame_start, vblank_start, render_ready, flip_done;
  logic [AW-1:0] display_base, render_base;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  int m_h, m_v, m_disp, m_rend;
  int m_queue[$];   // finished frames waiting for blanking (at most one kept)
  bit m_fs, m_vb, m_fd;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  flip_sync_ctrl #(
    .ADDR_W(AW), .BASE0(B0), .BASE1(B1), .BASE2(B2),
    .H_ACTIVE(HA), .H_BLANK(HB), .V_ACTIVE(VA), .V_BLANK(VB)
  ) i_flip_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .triple_en(triple_en),
    .flip_req(flip_req), .h_pos(h_pos), .v_pos(v_pos),
    .active_video(active_video), .frame_start(frame_start),
    .vblank_start(vblank_start), .display_base(display_base),
    .render_base(render_base), .render_ready(render_ready),
    .flip_done(flip_done)
  );

  function automatic logic [AW-1:0] addr_of(int i);
    return (i == 0) ? B0 : (i == 1) ? B1 : B2;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 h_pos", 64'(h_pos), 64'(m_h));
    check("R2 v_pos", 64'(v_pos), 64'(m_v));
    check("R2 active_video", 64'(active_video), 64'((m_h < HA) && (m_v < VA)));
    check("R3 frame_start", 64'(frame_start), 64'(m_fs));
    check("R3 vblank_start", 64'(vblank_start), 64'(m_vb));
    check({m_tag, " flip_done"}, 64'(flip_done), 64'(m_fd));
    check({m_tag, " display_base"}, 64'(display_base), 64'(addr_of(m_disp)));
    check({m_tag, " render_base"}, 64'(render_base), 64'(addr_of(m_rend)));
    check("R5 render_ready", 64'(render_ready),
          64'(triple_en || (m_queue.size() == 0)));
  endtask

  // Advance the model by one clock with the inputs now applied.
  task automatic model_step(bit tk, bit rq, bit tri_mode, bit at_edge);
    bit into_blank, into_frame;
    into_blank = tk && (m_h == HT-1) && (m_v == VA-1);
    into_frame = tk && (m_h == HT-1) && (m_v == VT-1);
    m_tag = tri_mode ? "R8" : "R6";
    if (rq) begin
      if (tri_mode) begin
        int freed;
        if (m_queue.size() != 0) freed = m_queue.pop_front();   // R8
        else freed = 3 - m_disp - m_rend;                        // R7
        m_queue.push_back(m_rend);
        m_rend = freed;
      end else if (m_queue.size() == 0) begin
        m_queue.push_back(m_rend);                               // R5
      end
      if (at_edge && into_blank) m_tag = "R9";
    end
    m_fd = 1'b0;
    if (into_blank && m_queue.size() != 0) begin
      int old_disp;
      old_disp = m_disp;
      m_disp = m_queue.pop_front();
      if (!tri_mode) m_rend = old_disp;
      m_fd = 1'b1;
    end else if (into_blank) begin
      m_tag = "R10";
    end
    m_fs = into_frame;
    m_vb = into_blank;
    if (tk) begin
      if (m_h == HT-1) begin
        m_h = 0;
        m_v = (m_v == VT-1) ? 0 : m_v + 1;
      end else m_h = m_h + 1;
    end
  endtask

  task automatic run_phase(int cycles, bit tri_mode, int req_div);
    for (int c = 0; c < cycles; c++) begin
      bit tk, rq, edge_hit;
      @(negedge clk);
      compare_all();
      tk = ($urandom_range(0, 7) != 0);
      edge_hit = tk && (m_h == HT-1) && (m_v == VA-1);
      rq = ($urandom_range(0, req_div-1) == 0);
      if (edge_hit && $urandom_range(0, 1) == 1) rq = 1'b1;   // R9 provocation
      if (c >= cycles - 3*HT*VT) rq = 1'b0;                   // drain before mode change
      pix_tick = tk;
      flip_req = rq;
      triple_en = tri_mode;
      model_step(tk, rq, tri_mode, edge_hit);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pix_tick = 1'b0;
    triple_en = 1'b0;
    flip_req = 1'b0;
    m_h = 0; m_v = 0; m_disp = 0; m_rend = 1;
    m_fs = 0; m_vb = 0; m_fd = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 display_base", 64'(display_base), 64'(B0));
    check("R1 render_base", 64'(render_base), 64'(B1));
    check("R1 render_ready", 64'(render_ready), 64'd1);
    check("R1 flip_done", 64'(flip_done), 64'd0);
    check("R1 position", 64'({h_pos, v_pos}), 64'd0);
    run_phase(1500, 1'b0, 30);   // two buffers
    run_phase(2000, 1'b1, 12);   // three buffers, frequent repeats (R8)
    run_phase(1500, 1'b1, 200);  // three buffers, sparse requests (R10)
    run_phase(1500, 1'b0, 8);    // two buffers, requests while waiting
    @(negedge clk);
    compare_all();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule